// File: doc/BRIEF.md
# USB Link Power Management Handshake Responder

This block makes the device-side decision when a USB Link Power Management (LPM) token arrives. Software arms it through a small control register that holds a two-bit LPM enable field and a request bit. When a token is reported, the block picks the handshake to return from three inputs: the enable field, the request bit, and whether any transmit FIFO still holds data. It then updates the request bit, records the event in sticky interrupt status, and signals entry to the L1 sleep state when the link is allowed to sleep.

The surrounding controller decodes packets, drives the PHY and owns the FIFOs. It feeds this block a one-cycle token strobe and a per-FIFO non-empty vector. It sends the returned handshake code on the bus, and uses the L1 pulse to start its sleep sequence. Software sees the control, enable and status values on read-back ports and clears status with a strobe.

Top module: `lpm_responder`

## Requirements
- R1: After reset the control read-back, the interrupt-enable read-back, the status and `irq` are all zero, and `hs_valid` and `l1_enter` are low.
- R2: A write with `wr_sel`=0 loads the enable field from `wr_data[3:2]` and the request bit from `wr_data[0]`. The control read-back shows them at the same positions, and every other bit reads 0. Enable and request written together in one write are honoured together.
- R3: A token that arrives while the enable field is 2'b11, the request bit is 1 and every `fifo_busy` bit is 0 gives, one cycle later, `hs_valid`=1 with code 1 (ACK) and a one-cycle `l1_enter` pulse. The request bit clears, and status bits 0 (sleep entered) and 2 (ACK) set.
- R4: A token that arrives while the enable field is 2'b11, the request bit is 1 and any `fifo_busy` bit is 1 gives code 2 (NYET), no `l1_enter` and status bit 1 set. The request bit stays 1.
- R5: A token that arrives while the enable field is not 2'b11 gives code 3 (STALL, not compatible) and status bit 3 set. There is no `l1_enter` and the request bit is unchanged.
- R6: A token that arrives while the enable field is 2'b11 and the request bit is 0 gives code 2 (NYET) and status bit 1 set, with no `l1_enter`.
- R7: In a cycle after which no token was received, `hs_valid` and `l1_enter` are low and `hs_code` is 0. `hs_valid` is never high with code 0.
- R8: A write with `wr_sel`=1 loads the six interrupt enables from `wr_data[5:0]`, which read back unchanged, and leaves the control register as it was.
- R9: `irq` is high exactly when some status bit and the matching enable bit are both 1.
- R10: Status bits stay set until `stat_clr` is pulsed, which clears them all. An event in the same cycle as the clear stays set.
- R11: A token in the same cycle as a control write is decided on the register values before the write, and the written value is what remains afterwards, even when the decision would have cleared the request bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the interrupt enables |
| wr_data | input | 8 | Write data |
| stat_clr | input | 1 | Clears all status bits |
| lpm_tok | input | 1 | One-cycle strobe: an LPM token was received |
| fifo_busy | input | 4 | One bit per transmit FIFO, 1 when that FIFO holds data |
| ctrl_rd | output | 8 | Control register read-back |
| ien_rd | output | 6 | Interrupt enable read-back |
| status_rd | output | 6 | Sticky status read-back |
| hs_valid | output | 1 | Handshake code is valid this cycle |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NYET, 3 STALL |
| l1_enter | output | 1 | One-cycle pulse: enter L1 |
| irq | output | 1 | Masked interrupt |

## Verification
On every cycle, the assertions check that the L1 pulse appears only together with an ACK handshake. They also check that a valid handshake never carries code 0, that a quiet cycle yields no handshake, that status bits stay set when no clear is given, and that the request bit clears after an ACK and is held after a NYET. Only the bench's scenarios can show that each handshake code is right across the whole space of enable values, request values and FIFO occupancy patterns. The same holds for the full 64-value mask behaviour of `irq`, and for the ordering when a write or a clear lands in the same cycle as a token.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NYET  = 2'd2,
        HS_STALL = 2'd3
    } hs_code_e;

    localparam int ST_W     = 6;
    localparam int ST_SLEEP = 0;
    localparam int ST_NYET  = 1;
    localparam int ST_ACK   = 2;
    localparam int ST_NC    = 3;
    localparam int ST_RES   = 4;
    localparam int ST_ERR   = 5;

    localparam logic [1:0] LPM_ON = 2'b11;

    typedef struct packed {
        logic [1:0] lpm_en;
        logic       req;
    } ctrl_t;

endpackage

// File: rtl/lpm_ctrl_regs.sv
module lpm_ctrl_regs
    import lpm_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int EN_LSB = 2,
    parameter int REQ_B  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ack_clr,
    output ctrl_t            ctrl
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ack_clr) begin
            ctrl_d.req = 1'b0;
        end
        if (wr_en) begin
            ctrl_d.lpm_en = wr_data[EN_LSB +: 2];
            ctrl_d.req    = wr_data[REQ_B];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

    // R2: a write always decides the next register value
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q.req == $past(wr_data[REQ_B])));

endmodule

// File: rtl/lpm_decider.sv
module lpm_decider
    import lpm_pkg::*;
#(
    parameter int NUM_FIFO = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tok,
    input  ctrl_t               ctrl,
    input  logic [NUM_FIFO-1:0] fifo_busy,
    output logic                ack_clr,
    output logic [ST_W-1:0]     evt,
    output logic                hs_valid,
    output hs_code_e            hs_code,
    output logic                l1_enter
);

    typedef struct packed {
        logic     valid;
        hs_code_e code;
        logic     l1;
    } hs_t;

    hs_t hs_d, hs_q;
    logic any_busy;
    logic enabled;

    assign any_busy = |fifo_busy;
    assign enabled  = (ctrl.lpm_en == LPM_ON);

    always_comb begin
        hs_d    = '0;
        ack_clr = 1'b0;
        evt     = '0;
        if (tok) begin
            hs_d.valid = 1'b1;
            if (!enabled) begin
                hs_d.code   = HS_STALL;
                evt[ST_NC]  = 1'b1;
            end else if (ctrl.req && !any_busy) begin
                hs_d.code      = HS_ACK;
                hs_d.l1        = 1'b1;
                ack_clr        = 1'b1;
                evt[ST_ACK]    = 1'b1;
                evt[ST_SLEEP]  = 1'b1;
            end else begin
                hs_d.code     = HS_NYET;
                evt[ST_NYET]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign hs_valid = hs_q.valid;
    assign hs_code  = hs_q.code;
    assign l1_enter = hs_q.l1;

    // R7: a valid handshake always carries a real code
    p_valid_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> (hs_code != HS_NONE));

    // R7: no token, no handshake in the next cycle
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tok |=> (!hs_valid && !l1_enter));

    // R5: a disabled link never sleeps
    p_stall_no_l1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok && !enabled) |=> (!l1_enter && hs_code == HS_STALL));

endmodule

// File: rtl/lpm_irq.sv
module lpm_irq
    import lpm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ST_W-1:0] wr_data,
    input  logic            clr,
    input  logic [ST_W-1:0] evt,
    output logic [ST_W-1:0] ien,
    output logic [ST_W-1:0] status,
    output logic            irq
);

    typedef struct packed {
        logic [ST_W-1:0] ien;
        logic [ST_W-1:0] st;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic [ST_W-1:0] st_next;
    logic [ST_W-1:0] hit;

    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        assign st_next[i] = evt[i] | (s_q.st[i] & ~clr);
        assign hit[i]     = s_q.st[i] & s_q.ien[i];
    end

    always_comb begin
        s_d    = s_q;
        s_d.st = st_next;
        if (wr_en) begin
            s_d.ien = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ien    = s_q.ien;
    assign status = s_q.st;
    assign irq    = |hit;

    // R10: without a clear, no status bit drops
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status & $past(status)) == $past(status)));

    // R10: an event is recorded even under a clear
    p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

endmodule

// File: rtl/lpm_responder.sv
module lpm_responder
    import lpm_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    parameter int REG_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                stat_clr,
    input  logic                lpm_tok,
    input  logic [NUM_FIFO-1:0] fifo_busy,
    output logic [REG_W-1:0]    ctrl_rd,
    output logic [ST_W-1:0]     ien_rd,
    output logic [ST_W-1:0]     status_rd,
    output logic                hs_valid,
    output logic [1:0]          hs_code,
    output logic                l1_enter,
    output logic                irq
);

    localparam int EN_LSB = 2;
    localparam int REQ_B  = 0;

    ctrl_t           ctrl;
    logic            ack_clr;
    logic [ST_W-1:0] evt;
    hs_code_e        code;
    logic            wr_ctrl;
    logic            wr_ien;

    assign wr_ctrl = wr_en && !wr_sel;
    assign wr_ien  = wr_en &&  wr_sel;

    lpm_ctrl_regs #(
        .REG_W  (REG_W),
        .EN_LSB (EN_LSB),
        .REQ_B  (REQ_B)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ctrl),
        .wr_data (wr_data),
        .ack_clr (ack_clr),
        .ctrl    (ctrl)
    );

    lpm_decider #(
        .NUM_FIFO (NUM_FIFO)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok       (lpm_tok),
        .ctrl      (ctrl),
        .fifo_busy (fifo_busy),
        .ack_clr   (ack_clr),
        .evt       (evt),
        .hs_valid  (hs_valid),
        .hs_code   (code),
        .l1_enter  (l1_enter)
    );

    lpm_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ien),
        .wr_data (wr_data[ST_W-1:0]),
        .clr     (stat_clr),
        .evt     (evt),
        .ien     (ien_rd),
        .status  (status_rd),
        .irq     (irq)
    );

    assign hs_code = code;

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[EN_LSB +: 2] = ctrl.lpm_en;
        ctrl_rd[REQ_B]       = ctrl.req;
    end

    // R3: sleep is entered only with an ACK
    p_l1_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        l1_enter |-> (hs_valid && hs_code == 2'd1));

    // R3: ACK clears the request when no write competes
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_tok && ctrl.lpm_en == LPM_ON && ctrl.req && fifo_busy == '0 && !wr_ctrl)
        |=> (ctrl_rd[REQ_B] == 1'b0));

    // R4: NYET keeps the request armed
    p_nyet_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_tok && ctrl.lpm_en == LPM_ON && ctrl.req && fifo_busy != '0 && !wr_ctrl)
        |=> (ctrl_rd[REQ_B] == 1'b1 && !l1_enter));

    // R9: an enabled, set status bit raises the line
    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_rd & ien_rd) != '0) |-> irq);

endmodule

// File: tb/lpm_responder_test.sv
module lpm_responder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       stat_clr = 1'b0;
    logic       lpm_tok = 1'b0;
    logic [3:0] fifo_busy = '0;
    logic [7:0] ctrl_rd;
    logic [5:0] ien_rd;
    logic [5:0] status_rd;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       l1_enter;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lpm_responder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .stat_clr  (stat_clr),
        .lpm_tok   (lpm_tok),
        .fifo_busy (fifo_busy),
        .ctrl_rd   (ctrl_rd),
        .ien_rd    (ien_rd),
        .status_rd (status_rd),
        .hs_valid  (hs_valid),
        .hs_code   (hs_code),
        .l1_enter  (l1_enter),
        .irq       (irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear_status();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    // token for one cycle; returns at the negedge after the registering edge
    task automatic token(input logic [3:0] busy);
        @(negedge clk);
        lpm_tok = 1'b1; fifo_busy = busy;
        @(negedge clk);
        lpm_tok = 1'b0; fifo_busy = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ctrl", int'(ctrl_rd), 0);
        chk("R1", "ien", int'(ien_rd), 0);
        chk("R1", "status", int'(status_rd), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "hs_valid", int'(hs_valid), 0);
        chk("R1", "l1", int'(l1_enter), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 field positions and masking
        wr(1'b0, 8'hFF);
        chk("R2", "ctrl readback", int'(ctrl_rd), 8'h0D);
        wr(1'b0, 8'hF2);
        chk("R2", "ctrl readback masked", int'(ctrl_rd), 0);

        // R8 enables, control untouched
        wr(1'b0, 8'h08);
        wr(1'b1, 8'hFF);
        chk("R8", "ien readback", int'(ien_rd), 6'h3F);
        chk("R8", "ctrl untouched", int'(ctrl_rd), 8'h08);

        // Sweep R3 R4 R5 R6 R7 over enable, request and FIFO occupancy
        for (int en = 0; en < 4; en++) begin
            for (int rq = 0; rq < 2; rq++) begin
                for (int b = 0; b < 16; b++) begin
                    int ecode, est, el1, ereq;
                    string tag;
                    wr(1'b0, 8'((en << 2) | rq));
                    clear_status();
                    chk("R10", "status cleared", int'(status_rd), 0);
                    if (en != 3) begin
                        ecode = 3; est = 8; el1 = 0; ereq = rq; tag = "R5";
                    end else if (rq == 0) begin
                        ecode = 2; est = 2; el1 = 0; ereq = 0; tag = "R6";
                    end else if (b == 0) begin
                        ecode = 1; est = 5; el1 = 1; ereq = 0; tag = "R3";
                    end else begin
                        ecode = 2; est = 2; el1 = 0; ereq = 1; tag = "R4";
                    end
                    token(4'(b));
                    chk(tag, "hs_valid", int'(hs_valid), 1);
                    chk(tag, "hs_code", int'(hs_code), ecode);
                    chk(tag, "l1_enter", int'(l1_enter), el1);
                    chk(tag, "status", int'(status_rd), est);
                    chk(tag, "request", int'(ctrl_rd[0]), ereq);
                    chk("R9", "irq all enabled", int'(irq), 1);
                    @(negedge clk);
                    chk("R7", "hs_valid quiet", int'(hs_valid), 0);
                    chk("R7", "hs_code quiet", int'(hs_code), 0);
                    chk("R7", "l1 quiet", int'(l1_enter), 0);
                end
            end
        end

        // R9 mask sweep with NYET+STALL status (bits 1 and 3)
        wr(1'b0, 8'h00);
        clear_status();
        token(4'h0);
        wr(1'b0, 8'h0C);
        token(4'h0);
        chk("R10", "sticky accumulate", int'(status_rd), 8'h0A);
        for (int m = 0; m < 64; m++) begin
            wr(1'b1, 8'(m));
            chk("R9", "irq masked", int'(irq), ((m & 8'h0A) != 0) ? 1 : 0);
        end

        // R10 clear in the same cycle as an event
        @(negedge clk);
        stat_clr = 1'b1; lpm_tok = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0; lpm_tok = 1'b0;
        chk("R10", "event beats clear", int'(status_rd), 2);

        // R11 write together with token: decided on old value
        wr(1'b0, 8'h00);
        clear_status();
        @(negedge clk);
        lpm_tok = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h0D;
        @(negedge clk);
        lpm_tok = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R11", "old value stall", int'(hs_code), 3);
        chk("R11", "write stands", int'(ctrl_rd), 8'h0D);
        // R2 armed in one write: next token gets ACK
        token(4'h0);
        chk("R2", "same-write arm ack", int'(hs_code), 1);
        // R11 ACK with concurrent re-arm keeps request
        wr(1'b0, 8'h0D);
        @(negedge clk);
        lpm_tok = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h0D;
        @(negedge clk);
        lpm_tok = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R11", "ack code", int'(hs_code), 1);
        chk("R11", "re-arm wins", int'(ctrl_rd[0]), 1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule